// File: doc/BRIEF.md
# Receive Pad Stripping Filter

This block sits on the receive byte path of an Ethernet-style MAC, after frame delimiting and before the path to host memory. It sees each frame as a stream of bytes, one per cycle, with a flag on the final byte. The frame starts with a 14-byte header whose last two bytes carry the length/type value. The last four bytes of the frame are the frame check sequence (FCS). When stripping is enabled and the length value is below the 46-byte minimum data size, the filter drops the pad bytes that sit between the stated data and the FCS. The host therefore never receives them.

The FCS is always forwarded after the retained data, so a downstream checker can still verify the CRC. This works because the stream passes through a four-byte delay line. When the final byte arrives, the four bytes held in the line are exactly the FCS, and they are drained over the next four cycles. Along with each forwarded byte the filter reports a running count. On the byte that carries the end-of-frame marker, that count is the frame's forwarded length. Frames must be at least 18 bytes long. Frames must also be separated by at least four idle input cycles, which is the window in which the FCS is drained.

Top module: `rx_pad_trim`

## Requirements
- R1: When the enable sampled for a frame is low, every byte of the frame is forwarded unchanged and in order.
- R2: The length value is taken from frame byte 12 (most significant) and byte 13 (least significant), both counted from zero. Both bytes take part in the comparison.
- R3: When the frame's sampled enable is high and the length value L is below 46, bytes at positions 14+L up to N-5 are dropped, where N is the frame length. All other bytes are forwarded.
- R4: A length value of 46 or more, including type values of 0x0600 and above, forwards the whole frame even with stripping enabled.
- R5: The last four bytes of every frame are always forwarded, and `out_last` is high together with the final one. These four bytes leave on the four cycles that follow the acceptance of the input's last byte, and the input must stay idle during those cycles.
- R6: `out_count` equals 1 on the first forwarded byte of a frame and rises by one on each further forwarded byte. On the `out_last` byte it therefore equals the number of bytes forwarded for that frame.
- R7: `strip_en` is sampled with the first byte of a frame. Changes on it during the rest of that frame have no effect on that frame.
- R8: Forwarded bytes leave in the order they arrived, and frames sent at the minimum gap are kept apart, each with its own count.
- R9: During reset and on the first cycle after it, `out_valid` and `out_last` are low and `out_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strip_en | input | 1 | Pad stripping enable, sampled at each frame's first byte |
| in_valid | input | 1 | Input byte present this cycle |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the last of the frame |
| out_valid | output | 1 | Forwarded byte present |
| out_data | output | 8 | Forwarded byte |
| out_last | output | 1 | Forwarded byte is the last of the frame |
| out_count | output | 16 | Bytes forwarded in this frame, including the current one |

## Verification
Two pieces of work can fall on the same clock edge. The edge that accepts a frame's last input byte also decides whether to keep or drop the byte leaving the delay line, and it arms the FCS drain. The bench provokes this in two ways. In one, the strip cut falls exactly on that outgoing byte (L=45, N=64, where byte 59 must go). In the other, no pad is present at all (L=45, N=63). Frames are driven back to back at the four-cycle minimum gap, with `strip_en` toggled mid-frame. A scoreboard judges every forwarded byte, its end flag and its running count against the sequence expected from the requirements.

// File: rtl/rx_pad_trim_pkg.sv
// Shared types for the receive pad stripping filter.
package rx_pad_trim_pkg;
    typedef logic [7:0] byte_t;
endpackage

// File: rtl/rx_pad_trim_parse.sv
// Frame position tracker and length capture.
// Counts accepted bytes within the current frame.
// Latches the stripping enable on byte 0.
// Captures the 16-bit length/type value from the two header bytes that precede the data.
// Assumes in_last marks exactly one byte per frame.
module rx_pad_trim_parse
    import rx_pad_trim_pkg::*;
#(
    parameter int HDR_BYTES = 14,
    parameter int MIN_DATA  = 46,
    parameter int CNT_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strip_en,
    input  logic             in_valid,
    input  byte_t            in_data,
    input  logic             in_last,
    output logic [CNT_W-1:0] pos,
    output logic [15:0]      len,
    output logic             strip_frame
);
    localparam logic [CNT_W-1:0] LEN_HI_POS = CNT_W'(HDR_BYTES - 2);
    localparam logic [CNT_W-1:0] LEN_LO_POS = CNT_W'(HDR_BYTES - 1);

    logic en_q;

    // Position of the next input byte within the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)        pos <= '0;
        else if (in_valid) pos <= in_last ? '0 : pos + 1'b1;
    end

    // Capture the length/type bytes, most significant byte first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len <= '0;
        end else if (in_valid) begin
            if (pos == LEN_HI_POS) len[15:8] <= in_data;
            if (pos == LEN_LO_POS) len[7:0]  <= in_data;
        end
    end

    // Sample the stripping enable once per frame, on its first byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                     en_q <= 1'b0;
        else if (in_valid && pos == '0) en_q <= strip_en;
    end

    // Stripping applies only to short data fields.
    assign strip_frame = en_q && (len < 16'(MIN_DATA));
endmodule

// File: rtl/rx_pad_trim_delay.sv
// Byte delay line of DEPTH stages.
// On each shift, a new byte enters stage 0 and the oldest byte is presented at dout.
// Once a frame has ended, the stages hold the frame's trailing check bytes.
module rx_pad_trim_delay
    import rx_pad_trim_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  shift,
    input  byte_t din,
    output byte_t dout
);
    byte_t stage [DEPTH];

    // Shift the byte chain by one position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
        end else if (shift) begin
            stage[0] <= din;
            for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
        end
    end

    assign dout = stage[DEPTH-1];
endmodule

// File: rtl/rx_pad_trim_emit.sv
// Output stage of the receive pad stripping filter.
// Decides per byte whether the byte leaving the delay line is forwarded.
// When the input's last byte is accepted, it drains the FCS bytes held in the line.
// It keeps the running forwarded count.
// Assumes the input stays idle while the drain is in progress.
module rx_pad_trim_emit
    import rx_pad_trim_pkg::*;
#(
    parameter int HDR_BYTES = 14,
    parameter int FCS_BYTES = 4,
    parameter int CNT_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic [CNT_W-1:0] pos,
    input  logic [15:0]      len,
    input  logic             strip_frame,
    input  byte_t            dline,
    output logic             flushing,
    output logic             out_valid,
    output byte_t            out_data,
    output logic             out_last,
    output logic [CNT_W-1:0] out_count
);
    localparam int FLUSH_W = $clog2(FCS_BYTES + 1);
    localparam int LIM_W   = CNT_W + 1;

    logic [FLUSH_W-1:0] flush_cnt;
    logic [CNT_W-1:0]   fwd_q;
    logic [LIM_W-1:0]   limit;
    logic               keep;

    assign flushing = (flush_cnt != '0);

    // Bytes leave the line FCS_BYTES positions behind the input.
    // The limit is therefore offset by that distance as well.
    assign limit = LIM_W'(HDR_BYTES + FCS_BYTES) + LIM_W'(len);
    assign keep  = (pos >= CNT_W'(FCS_BYTES)) &&
                   (!strip_frame || ({1'b0, pos} < limit));

    // Forward kept bytes, drain the FCS after the last byte and track the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_data  <= '0;
            out_count <= '0;
            fwd_q     <= '0;
            flush_cnt <= '0;
        end else begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            if (flushing) begin
                out_valid <= 1'b1;
                out_data  <= dline;
                out_count <= fwd_q + 1'b1;
                flush_cnt <= flush_cnt - 1'b1;
                if (flush_cnt == FLUSH_W'(1)) begin
                    out_last <= 1'b1;
                    fwd_q    <= '0;
                end else begin
                    fwd_q <= fwd_q + 1'b1;
                end
            end else if (in_valid) begin
                if (keep) begin
                    out_valid <= 1'b1;
                    out_data  <= dline;
                    out_count <= fwd_q + 1'b1;
                    fwd_q     <= fwd_q + 1'b1;
                end
                if (in_last) flush_cnt <= FLUSH_W'(FCS_BYTES);
            end
        end
    end

    // R5
    last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R5
    flush_emits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flushing |=> out_valid);

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> (!out_valid || out_count == $past(out_count) + 1'b1));

    // R9
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && !out_last && out_count == '0));
endmodule

// File: rtl/rx_pad_trim.sv
// Receive pad stripping filter (top).
// Passes a received frame through a short delay line.
// When enabled, drops the pad bytes between a short stated data field and the FCS.
// Frames must be at least HDR_BYTES+FCS_BYTES long.
// Frames must be separated by at least FCS_BYTES idle input cycles.
module rx_pad_trim
    import rx_pad_trim_pkg::*;
#(
    parameter int HDR_BYTES = 14,
    parameter int MIN_DATA  = 46,
    parameter int FCS_BYTES = 4,
    parameter int CNT_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strip_en,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_last,
    output logic [CNT_W-1:0] out_count
);
    logic [CNT_W-1:0] pos;
    logic [15:0]      len;
    logic             strip_frame;
    logic             flushing;
    byte_t            dline;
    byte_t            din;
    logic             shift;

    // During the drain, zeros are shifted in behind the FCS.
    assign shift = in_valid || flushing;
    assign din   = flushing ? '0 : in_data;

    rx_pad_trim_parse #(
        .HDR_BYTES(HDR_BYTES), .MIN_DATA(MIN_DATA), .CNT_W(CNT_W)
    ) u_parse (
        .clk(clk), .rst_n(rst_n), .strip_en(strip_en),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .pos(pos), .len(len), .strip_frame(strip_frame)
    );

    rx_pad_trim_delay #(.DEPTH(FCS_BYTES)) u_delay (
        .clk(clk), .rst_n(rst_n), .shift(shift), .din(din), .dout(dline)
    );

    rx_pad_trim_emit #(
        .HDR_BYTES(HDR_BYTES), .FCS_BYTES(FCS_BYTES), .CNT_W(CNT_W)
    ) u_emit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
        .pos(pos), .len(len), .strip_frame(strip_frame), .dline(dline),
        .flushing(flushing), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .out_count(out_count)
    );

    // R5
    idle_during_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flushing |-> !in_valid);
endmodule

// File: tb/rx_pad_trim_bench.sv
module rx_pad_trim_bench;
    localparam int CLK_PERIOD = 10;
    localparam int FCS_N      = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strip_en = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_last;
    logic [15:0] out_count;

    int checks = 0;
    int errors = 0;

    // Each entry packs {last, count[15:0], data[7:0]}.
    logic [24:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_pad_trim u_rx_pad_trim (
        .clk(clk), .rst_n(rst_n), .strip_en(strip_en),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .out_count(out_count)
    );

    task automatic check(input string req, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: builds a frame, queues the expected output and drives it at the minimum gap.
    task automatic send_frame(input logic en, input logic [15:0] lenf, input int n,
                              input int seed, input logic toggle, input string tag);
        logic [7:0] b [128];
        logic       strip;
        int         kept;
        int         total;
        int         cnt;
        strip = en && (lenf < 16'd46);
        for (int i = 0; i < n; i++) b[i] = 8'((i * 37 + seed * 11) ^ 8'h5A);
        b[12] = lenf[15:8];
        b[13] = lenf[7:0];
        total = 0;
        for (int i = 0; i < n; i++)
            if (!strip || i < 14 + int'(lenf) || i >= n - FCS_N) total++;
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            if (!strip || i < 14 + int'(lenf) || i >= n - FCS_N) begin
                cnt++;
                kept = cnt;
                exp_q.push_back({(kept == total), 16'(kept), b[i]});
                tag_q.push_back(tag);
            end
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = b[i];
            in_last  = (i == n - 1);
            strip_en = (i == 0) ? en : (toggle ? ~en : en);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (FCS_N - 1) @(negedge clk);
    endtask

    // Monitor: compares each forwarded byte against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R8", 1'b0, int'(out_data), -1);
            end else begin
                logic [24:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, out_data == e[7:0], int'(out_data), int'(e[7:0]));
                check("R5", out_last == e[24], int'(out_last), int'(e[24]));
                check("R6", out_count == e[23:8], int'(out_count), int'(e[23:8]));
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: outputs quiet during reset
        check("R9", !out_valid && !out_last && out_count == 16'd0, int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: outputs quiet on the first cycle after reset
        check("R9", !out_valid && !out_last && out_count == 16'd0, int'(out_count), 0);

        send_frame(1'b1, 16'd10,    64,  1, 1'b0, "R3");
        send_frame(1'b1, 16'd46,    64,  2, 1'b0, "R4");
        send_frame(1'b1, 16'd45,    64,  3, 1'b0, "R3");
        send_frame(1'b1, 16'h0800,  64,  4, 1'b0, "R4");
        send_frame(1'b0, 16'd10,    64,  5, 1'b0, "R1");
        send_frame(1'b1, 16'd0,     64,  6, 1'b0, "R3");
        send_frame(1'b1, 16'd10,    70,  7, 1'b1, "R7");
        send_frame(1'b0, 16'd20,    66,  8, 1'b1, "R7");
        send_frame(1'b1, 16'h0105,  60,  9, 1'b0, "R2");
        send_frame(1'b1, 16'd45,    63, 10, 1'b0, "R3");
        send_frame(1'b1, 16'd1,    100, 11, 1'b0, "R6");
        send_frame(1'b0, 16'h0600,  18, 12, 1'b0, "R1");

        repeat (20) @(negedge clk);
        // R8: every expected byte has been delivered
        check("R8", exp_q.size() == 0, exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule